// File: doc/BRIEF.md
# Cascaded Master/Slave PWM Timer Pair

Two up-counting PWM timers run from one system clock. The master timer divides the clock through a programmable prescaler, counts from zero up to its reload value and wraps. It drives a pulse-width output and a trigger line. The trigger line can carry one of three signals: a one-cycle pulse on every wrap, the master's compare reference level, or the master's run-enable level.

The slave timer has its own reload and compare values and its own pulse-width output. Its count clock is chosen by a slave-mode field. In free mode it advances on every system clock. In gated mode it advances on every system clock while the trigger is high. In trigger-clocked mode it advances once per rising edge of the trigger. With the same trigger, gated and trigger-clocked modes can give quite different slave frequencies.

All settings are written through a small address/data/write-enable port. While a timer is running, new reload, compare and prescaler values are held back until that timer's next wrap, so a period never changes part-way through.

Top module: `cascaded_pwm_timer`

## Requirements
- R1: Each timer counts 0, 1, … up to its active reload value and then returns to 0. The master advances once every (prescaler+1) clocks, so its period is (reload+1)·(prescaler+1) clocks.
- R2: A timer's reference level is high while its counter is below its active compare value. Compare 0 keeps it low. A compare above the reload keeps it high.
- R3: Each pin equals the reference level XOR its polarity bit, and is forced to 0 when its output-enable bit is 0.
- R4: With trigger select 2, the trigger output carries a one-clock pulse for each master wrap. The pulse comes one clock after the wrap edge, while the master counter reads 0.
- R5: Slave mode 7 advances the slave counter once per rising edge of the trigger. With trigger select 2 this gives a slave period of (slave reload+1) master periods, and (slave compare) master periods of active output.
- R6: Slave mode 5 advances the slave counter on every clock in which the trigger is high.
- R7: Slave mode 0, and any slave-mode code other than 5 or 7, advances the slave on every clock while it is enabled.
- R8: Trigger select 4 drives the trigger with the master's reference level. Trigger select 0 drives it with the master's counter-enable bit. Every trigger source is registered once.
- R9: While a timer is enabled, written reload, compare and prescaler values take effect only at its next wrap. While it is disabled, they take effect on the next clock.
- R10: A timer whose enable bit is 0 holds its counter at 0.
- R11: Register addresses: 0 control, 1 master prescaler, 2 master reload, 3 master compare, 4 slave reload, 5 slave compare. Control bits: 0 master enable, 1 slave enable, 2 master output enable, 3 master polarity, 4 slave output enable, 5 slave polarity, 8:6 slave mode, 11:9 trigger select.
- R12: After reset, both pins and the trigger output are 0, and all control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| mst_pwm | output | 1 | Master pulse-width output |
| slv_pwm | output | 1 | Slave pulse-width output |
| mst_trig | output | 1 | Registered master trigger |

## Verification
The hardest case to reach is gated counting driven by the master's compare reference. There the slave advances in bursts, several counts in a row followed by long pauses, so its output is periodic only across several master periods. The stimulus picks a master compare and a slave reload that make the slave wrap exactly every second master period. It then measures a full steady-state slave period after skipping the first one. The other hard case is a compare write that lands just after the master wraps. That write is timed off the observed rising edge of the master pin.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_MPSC = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_MARR = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_MCMP = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_SARR = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_SCMP = 3'd5;
    localparam int NUM_SHADOW = 5;

    typedef enum logic [2:0] {
        SLV_FREE   = 3'd0,
        SLV_GATED  = 3'd5,
        SLV_EXTCLK = 3'd7
    } slv_mode_e;

    typedef enum logic [2:0] {
        TRG_ENABLE = 3'd0,
        TRG_UPDATE = 3'd2,
        TRG_REF    = 3'd4
    } trg_src_e;

    typedef struct packed {
        logic [2:0] trg_sel;
        logic [2:0] slv_mode;
        logic       s_pol;
        logic       s_oe;
        logic       m_pol;
        logic       m_oe;
        logic       s_cen;
        logic       m_cen;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    function automatic slv_mode_e decode_mode(input logic [2:0] raw);
        case (raw)
            3'd5:    return SLV_GATED;
            3'd7:    return SLV_EXTCLK;
            default: return SLV_FREE;
        endcase
    endfunction

    function automatic logic pick_trigger(input logic [2:0] sel, input logic en,
                                          input logic upd, input logic ref_lvl);
        case (sel)
            3'd0:    return en;
            3'd2:    return upd;
            3'd4:    return ref_lvl;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic drive_pin(input logic ref_lvl, input logic oe, input logic pol);
        return oe & (ref_lvl ^ pol);
    endfunction

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  m_psc,
    output logic [CNT_W-1:0]  m_arr,
    output logic [CNT_W-1:0]  m_cmp,
    output logic [CNT_W-1:0]  s_arr,
    output logic [CNT_W-1:0]  s_cmp
);

    logic [CNT_W-1:0] shadow [NUM_SHADOW];

    // reload registers reset to full scale, all others to zero
    function automatic logic [CNT_W-1:0] shadow_init(input int idx);
        if (idx == int'(ADR_MARR) - 1 || idx == int'(ADR_SARR) - 1)
            return '1;
        return '0;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && wr_addr == ADR_CTRL) begin
            ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SHADOW; i++) begin
            if (rst)
                shadow[i] <= shadow_init(i);
            else if (wr_en && int'(wr_addr) == i + 1)
                shadow[i] <= wr_data;
        end
    end

    assign m_psc = shadow[int'(ADR_MPSC) - 1];
    assign m_arr = shadow[int'(ADR_MARR) - 1];
    assign m_cmp = shadow[int'(ADR_MCMP) - 1];
    assign s_arr = shadow[int'(ADR_SARR) - 1];
    assign s_cmp = shadow[int'(ADR_SCMP) - 1];

endmodule

// File: rtl/cpwm_prescaler.sv
module cpwm_prescaler #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cen,
    input  logic             upd,
    input  logic [CNT_W-1:0] psc_sh,
    output logic             tick
);

    logic [CNT_W-1:0] psc_act;
    logic [CNT_W-1:0] div_cnt;

    assign tick = cen && (div_cnt == psc_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            psc_act <= '0;
            div_cnt <= '0;
        end else begin
            if (!cen || upd)
                psc_act <= psc_sh;
            if (!cen || tick)
                div_cnt <= '0;
            else
                div_cnt <= div_cnt + 1'b1;
        end
    end

    // R1
    div_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        div_cnt <= psc_act);

endmodule

// File: rtl/cpwm_unit.sv
module cpwm_unit
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cen,
    input  logic             tick_en,
    input  logic [CNT_W-1:0] arr_sh,
    input  logic [CNT_W-1:0] cmp_sh,
    input  logic             oe,
    input  logic             pol,
    output logic [CNT_W-1:0] cnt,
    output logic             below,
    output logic             upd,
    output logic             pin
);

    logic [CNT_W-1:0] arr_act;
    logic [CNT_W-1:0] cmp_act;
    logic             step;

    assign step  = cen && tick_en;
    assign upd   = step && (cnt == arr_act);
    assign below = cnt < cmp_act;
    assign pin   = drive_pin(below, oe, pol);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            arr_act <= '1;
            cmp_act <= '0;
        end else begin
            if (!cen)
                cnt <= '0;
            else if (step)
                cnt <= upd ? '0 : cnt + 1'b1;
            if (!cen || upd) begin
                arr_act <= arr_sh;
                cmp_act <= cmp_sh;
            end
        end
    end

    // R1
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= arr_act);

    // R1
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        upd |=> (cnt == '0));

    // R9
    preload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cen && !upd) |=> ($stable(cmp_act) && $stable(arr_act)));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !cen |=> (cnt == '0));

endmodule

// File: rtl/cpwm_slave_ctl.sv
module cpwm_slave_ctl
    import cpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       trg,
    input  logic [2:0] mode_raw,
    output logic       tick_en
);

    logic      trg_d;
    slv_mode_e mode;

    assign mode = decode_mode(mode_raw);

    always_ff @(posedge clk) begin
        if (rst) trg_d <= 1'b0;
        else     trg_d <= trg;
    end

    always_comb begin
        case (mode)
            SLV_GATED:  tick_en = trg;
            SLV_EXTCLK: tick_en = trg && !trg_d;
            default:    tick_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/cascaded_pwm_timer.sv
module cascaded_pwm_timer
    import cpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              mst_pwm,
    output logic              slv_pwm,
    output logic              mst_trig
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] m_psc, m_arr, m_cmp, s_arr, s_cmp;
    logic [CNT_W-1:0] m_cnt, s_cnt;
    logic             m_tick, m_upd, m_below;
    logic             s_tick, s_upd, s_below;
    logic             trg_q;

    cpwm_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ctrl(ctrl), .m_psc(m_psc), .m_arr(m_arr), .m_cmp(m_cmp),
        .s_arr(s_arr), .s_cmp(s_cmp)
    );

    cpwm_prescaler #(.CNT_W(CNT_W)) psc_i (
        .clk(clk), .rst(rst), .cen(ctrl.m_cen), .upd(m_upd),
        .psc_sh(m_psc), .tick(m_tick)
    );

    cpwm_unit #(.CNT_W(CNT_W)) master_i (
        .clk(clk), .rst(rst), .cen(ctrl.m_cen), .tick_en(m_tick),
        .arr_sh(m_arr), .cmp_sh(m_cmp), .oe(ctrl.m_oe), .pol(ctrl.m_pol),
        .cnt(m_cnt), .below(m_below), .upd(m_upd), .pin(mst_pwm)
    );

    always_ff @(posedge clk) begin
        if (rst) trg_q <= 1'b0;
        else     trg_q <= pick_trigger(ctrl.trg_sel, ctrl.m_cen, m_upd, m_below);
    end

    assign mst_trig = trg_q;

    cpwm_slave_ctl slave_ctl_i (
        .clk(clk), .rst(rst), .trg(trg_q), .mode_raw(ctrl.slv_mode), .tick_en(s_tick)
    );

    cpwm_unit #(.CNT_W(CNT_W)) slave_i (
        .clk(clk), .rst(rst), .cen(ctrl.s_cen), .tick_en(s_tick),
        .arr_sh(s_arr), .cmp_sh(s_cmp), .oe(ctrl.s_oe), .pol(ctrl.s_pol),
        .cnt(s_cnt), .below(s_below), .upd(s_upd), .pin(slv_pwm)
    );

    // R4
    trig_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (mst_trig && ctrl.trg_sel == TRG_UPDATE && $stable(ctrl.trg_sel)) |-> (m_cnt == '0));

    // R5
    ext_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl.s_cen && decode_mode(ctrl.slv_mode) == SLV_EXTCLK && !trg_q)
        |=> $stable(s_cnt));

    // R2
    slave_wrap_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (s_upd && s_cmp != '0 && ctrl.s_cen && $stable(ctrl.s_cen)) |=> (s_below || !ctrl.s_cen));

endmodule

// File: tb/cascaded_pwm_timer_tb_top.sv
module cascaded_pwm_timer_tb_top;
    import cpwm_pkg::*;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [2:0]    wr_addr;
    logic [CW-1:0] wr_data;
    logic          mst_pwm, slv_pwm, mst_trig;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    cascaded_pwm_timer #(.CNT_W(CW)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mst_pwm(mst_pwm), .slv_pwm(slv_pwm), .mst_trig(mst_trig)
    );

    typedef struct packed {
        logic [15:0] psc, marr, mcmp, sarr, scmp;
        logic [2:0]  mode, tsel;
        int          mper, mhigh, sper, shigh;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{16'd0, 16'd9, 16'd3, 16'd4, 16'd2, 3'd7, 3'd2, 10, 3, 50, 20},
        '{16'd0, 16'd9, 16'd3, 16'd4, 16'd2, 3'd5, 3'd2, 10, 3, 50, 20},
        '{16'd0, 16'd9, 16'd4, 16'd7, 16'd4, 3'd5, 3'd4, 10, 4, 20, 10},
        '{16'd0, 16'd9, 16'd4, 16'd3, 16'd1, 3'd7, 3'd4, 10, 4, 40, 10},
        '{16'd2, 16'd4, 16'd2, 16'd2, 16'd1, 3'd7, 3'd2, 15, 6, 45, 15},
        '{16'd0, 16'd9, 16'd5, 16'd5, 16'd3, 3'd0, 3'd2, 10, 5, 6, 3}
    };

    task automatic check(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [CW-1:0] ctrl_word(input logic [2:0] tsel, input logic [2:0] mode,
        input logic spol, input logic soe, input logic mpol, input logic moe,
        input logic scen, input logic mcen);
        return CW'({tsel, mode, spol, soe, mpol, moe, scen, mcen});
    endfunction

    // slave enabled first, then master
    task automatic setup(input vec_t v, input logic mpol);
        do_reset();
        wr(ADR_MPSC, v.psc);
        wr(ADR_MARR, v.marr);
        wr(ADR_MCMP, v.mcmp);
        wr(ADR_SARR, v.sarr);
        wr(ADR_SCMP, v.scmp);
        wr(ADR_CTRL, ctrl_word(v.tsel, v.mode, 1'b0, 1'b1, mpol, 1'b1, 1'b1, 1'b0));
        wr(ADR_CTRL, ctrl_word(v.tsel, v.mode, 1'b0, 1'b1, mpol, 1'b1, 1'b1, 1'b1));
    endtask

    function automatic logic pin_of(input bit sl);
        return sl ? slv_pwm : mst_pwm;
    endfunction

    task automatic wait_rise(input bit sl, output bit ok);
        logic prev;
        prev = pin_of(sl);
        ok = 1'b0;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (!prev && pin_of(sl)) begin
                ok = 1'b1;
                return;
            end
            prev = pin_of(sl);
        end
    endtask

    task automatic measure(input bit sl, output int per, output int hi);
        bit ok1, ok2;
        logic prev;
        per = 0; hi = 0;
        wait_rise(sl, ok1);
        wait_rise(sl, ok2);
        if (!(ok1 && ok2)) return;
        per = 1; hi = 1; prev = 1'b1;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (!prev && pin_of(sl)) return;
            per++;
            if (pin_of(sl)) hi++;
            prev = pin_of(sl);
        end
    endtask

    function automatic string slave_tag(input logic [2:0] mode, input logic [2:0] tsel);
        if (tsel == 3'd4) return (mode == 3'd5) ? "R6/R8" : "R5/R8";
        if (mode == 3'd7) return "R5";
        if (mode == 3'd5) return "R6";
        return "R7";
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin : main
        int per, hi, cnt_hi, pulses, dbl;
        logic prev_t;
        bit ok;
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;

        // R12 reset state
        do_reset();
        @(negedge clk);
        check("R12 mst_pwm", int'(mst_pwm), 0);
        check("R12 slv_pwm", int'(slv_pwm), 0);
        check("R12 mst_trig", int'(mst_trig), 0);

        // table walk: R1 R2 master, R5..R8 slave per row
        for (int i = 0; i < 6; i++) begin
            setup(VECS[i], 1'b0);
            measure(1'b0, per, hi);
            check("R1 master period", per, VECS[i].mper);
            check("R2 master high", hi, VECS[i].mhigh);
            measure(1'b1, per, hi);
            check({slave_tag(VECS[i].mode, VECS[i].tsel), " slave period"}, per, VECS[i].sper);
            check({slave_tag(VECS[i].mode, VECS[i].tsel), " slave high"}, hi, VECS[i].shigh);
        end

        // R3 polarity inverted
        setup(VECS[0], 1'b1);
        measure(1'b0, per, hi);
        check("R3 inverted period", per, 10);
        check("R3 inverted high", hi, 7);

        // R3 output enable off
        setup(VECS[0], 1'b0);
        wr(ADR_CTRL, ctrl_word(3'd2, 3'd7, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1));
        cnt_hi = 0;
        for (int n = 0; n < 60; n++) begin
            @(negedge clk);
            cnt_hi += int'(mst_pwm) + int'(slv_pwm);
        end
        check("R3 disabled outputs", cnt_hi, 0);

        // R2 compare zero and compare above reload
        setup('{16'd0, 16'd9, 16'd0, 16'd4, 16'd2, 3'd7, 3'd2, 0, 0, 0, 0}, 1'b0);
        cnt_hi = 0;
        for (int n = 0; n < 40; n++) begin @(negedge clk); cnt_hi += int'(mst_pwm); end
        check("R2 compare zero", cnt_hi, 0);
        setup('{16'd0, 16'd9, 16'd12, 16'd4, 16'd2, 3'd7, 3'd2, 0, 0, 0, 0}, 1'b0);
        cnt_hi = 0;
        for (int n = 0; n < 40; n++) begin @(negedge clk); cnt_hi += int'(mst_pwm); end
        check("R2 compare above reload", cnt_hi, 40);

        // R4 trigger pulse count and width
        setup(VECS[0], 1'b0);
        repeat (25) @(negedge clk);
        pulses = 0; dbl = 0; prev_t = mst_trig;
        for (int n = 0; n < 100; n++) begin
            @(negedge clk);
            if (mst_trig) pulses++;
            if (mst_trig && prev_t) dbl++;
            prev_t = mst_trig;
        end
        check("R4 trigger pulses", pulses, 10);
        check("R4 trigger width", dbl, 0);

        // R9 compare write right after master wrap is deferred
        setup(VECS[0], 1'b0);
        wait_rise(1'b0, ok);
        wait_rise(1'b0, ok);
        wr_en = 1'b1; wr_addr = ADR_MCMP; wr_data = 16'd7;
        hi = 1;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (mst_pwm) hi++;
            else break;
        end
        check("R9 deferred compare", hi, 3);
        measure(1'b0, per, hi);
        check("R9 compare after wrap", hi, 7);

        // R8 trigger from master enable level: one slave edge only
        setup('{16'd0, 16'd9, 16'd3, 16'd3, 16'd1, 3'd7, 3'd0, 0, 0, 0, 0}, 1'b0);
        repeat (10) @(negedge clk);
        cnt_hi = 0;
        for (int n = 0; n < 60; n++) begin @(negedge clk); cnt_hi += int'(slv_pwm); end
        check("R8 enable-level trigger", cnt_hi, 0);

        // R10 slave disabled holds count at 0 (pin stays active)
        setup(VECS[5], 1'b0);
        wr(ADR_CTRL, ctrl_word(3'd2, 3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1));
        cnt_hi = 0;
        for (int n = 0; n < 30; n++) begin @(negedge clk); cnt_hi += int'(slv_pwm); end
        check("R10 slave held at zero", cnt_hi, 30);

        // R7 unlisted slave mode code behaves as free running
        setup('{16'd0, 16'd9, 16'd5, 16'd5, 16'd3, 3'd3, 3'd2, 0, 0, 0, 0}, 1'b0);
        measure(1'b1, per, hi);
        check("R7 unlisted mode period", per, 6);

        // R11 control bit 4 alone enables only the slave pin
        setup(VECS[5], 1'b0);
        wr(ADR_CTRL, ctrl_word(3'd2, 3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1));
        cnt_hi = 0;
        for (int n = 0; n < 30; n++) begin @(negedge clk); cnt_hi += int'(mst_pwm); end
        check("R11 master pin off", cnt_hi, 0);
        measure(1'b1, per, hi);
        check("R11 slave still running", per, 6);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule